// File: doc/BRIEF.md
# Punctured Rate-1/2 K=7 Hard-Decision Viterbi Decoder

This block decodes the inner convolutional code of a satellite receiver's forward error correction chain. The encoder has constraint length 7 (64 trellis states) and the generators 171 and 133 (octal). The block accepts received channel bits two per beat. Each bit comes with an erasure flag. Using a selectable puncturing pattern, it rebuilds the rate-1/2 symbol pairs, and positions the transmitter never sent become erased bits. A 64-state add-compare-select array with hard-decision Hamming branch metrics and a register-exchange survivor memory then produces the decoded bits. Each decoded bit is released on a valid/ready output.

In parallel, the decoded bits are re-encoded and compared with the channel bits that were actually received, skipping erased positions. Mismatches are accumulated over a programmable window of decoded bits. At the end of each window the total is latched and the accumulator restarts.

Both data interfaces are valid/ready. The input takes a beat only while at most one channel bit is already held. When the output holds a bit the consumer has not taken, the trellis stops advancing, so input back-pressure follows within two beats. The rate select and window length are plain levels. They are changed only while reset is asserted.

Top module: `k7_viterbi_dec`

## Requirements
- R1: The code word for a step is the 7-bit value {new bit, previous six bits with the newest first}. X is the parity of that word ANDed with 171 octal, and Y is the parity of that word ANDed with 133 octal. At rate_sel 0 (and at the spare value 3) every step carries X then Y, and an error-free stream decodes to exactly the encoded bits, in order.
- R2: At rate_sel 1 (rate 2/3) steps alternate between two phases starting at phase 0. Phase 0 carries X then Y. Phase 1 carries only Y, and its X is treated as erased. An error-free stream decodes exactly.
- R3: At rate_sel 2 (rate 3/4) steps cycle through three phases starting at phase 0. Phase 0 carries X then Y, phase 1 carries only Y, and phase 2 carries only X. An error-free stream decodes exactly.
- R4: Sparse hard bit errors in the received channel bits are corrected, so the decoded output still equals the encoded bits.
- R5: A bit with its erasure flag set adds nothing to any branch metric, whatever its value, and is never counted as a channel error.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_bit does not change. Each decoded bit is delivered exactly once.
- R7: in_ready is high exactly when the decoder holds at most one unconsumed channel bit. A beat transfers when in_valid and in_ready are both high, and in_bits[0] is the earlier channel bit of the pair.
- R8: Every decoded bit adds to an accumulator the number of non-erased received bits of its step that differ from the re-encoded bits. After win_len decoded bits the total appears on err_count, err_done pulses for one cycle, and the accumulator restarts from zero.
- R9: After reset, out_valid and err_done are low, err_count is zero and in_ready is high.
- R10: The decoded bit for step i is released only after step i+48 has been processed. No output appears before the 49th step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Puncturing mode: 0 rate 1/2, 1 rate 2/3, 2 rate 3/4, 3 as 0 |
| win_len | input | 16 | Decoded bits per error-count window |
| in_valid | input | 1 | Channel pair is presented |
| in_ready | output | 1 | Decoder can take a pair |
| in_bits | input | 2 | Two channel bits, bit 0 first |
| in_erase | input | 2 | Erasure flag for each channel bit |
| out_valid | output | 1 | Decoded bit is presented |
| out_ready | input | 1 | Consumer takes the decoded bit |
| out_bit | output | 1 | Decoded bit |
| err_count | output | 16 | Channel error total of the last complete window |
| err_done | output | 1 | One-cycle pulse when err_count is updated |

## Verification
A puncture phase that slips, or a wrong predecessor wiring in the trellis, corrupts the decoded stream. It also raises err_count even on a clean channel, within one survivor depth (48 steps) of the fault. Path metrics that drift instead of being normalised show up first as lost corrections on streams with injected errors. A broken delay between received symbols and re-encoded bits shows up as non-zero counts on clean streams, or wrong counts on dirty ones, in the first window. A fault in the buffer or handshake shows at the ports as lost or repeated output bits under a stalling consumer, or as in_ready staying high while the output is blocked.

// File: rtl/k7vit_pkg.sv
package k7vit_pkg;
  localparam int CONSTRAINT = 7;
  localparam int NSTATE = 1 << (CONSTRAINT - 1);
  localparam int SIDX_W = CONSTRAINT - 1;
  localparam logic [CONSTRAINT-1:0] GEN_X = 7'o171;
  localparam logic [CONSTRAINT-1:0] GEN_Y = 7'o133;

  typedef enum logic [1:0] {
    RATE_1_2 = 2'd0,
    RATE_2_3 = 2'd1,
    RATE_3_4 = 2'd2,
    RATE_SPARE = 2'd3
  } rate_e;

  // one depunctured trellis symbol; ex/ey mark erased positions
  typedef struct packed {
    logic x;
    logic y;
    logic ex;
    logic ey;
  } sym_t;

  // bit 1 = X branch bit, bit 0 = Y branch bit
  function automatic logic [1:0] code_pair(input logic [CONSTRAINT-1:0] w);
    return {^(w & GEN_X), ^(w & GEN_Y)};
  endfunction

  // Hamming distance over non-erased bits, 0..2
  function automatic logic [1:0] hamming(input sym_t s, input logic [1:0] c);
    logic dx, dy;
    dx = !s.ex && (s.x != c[1]);
    dy = !s.ey && (s.y != c[0]);
    return {1'b0, dx} + {1'b0, dy};
  endfunction
endpackage

// File: rtl/k7vit_depunct.sv
module k7vit_depunct
  import k7vit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_bits,
  input  logic [1:0] in_erase,
  input  logic       step_go,
  output logic       step_fire,
  output sym_t       sym
);
  logic [3:0] dbuf_q, ebuf_q;
  logic [1:0] cnt_q;
  logic [1:0] phase_q;
  logic       keep_x, keep_y, last_phase;
  logic [1:0] need, used;
  logic [3:0] dbuf_d, ebuf_d;
  logic [1:0] cnt_d;
  logic       take;
  rate_e      rate;

  assign rate = rate_e'(rate_sel);

  always_comb begin
    keep_x = 1'b1;
    keep_y = 1'b1;
    last_phase = 1'b1;
    case (rate)
      RATE_2_3: begin
        keep_x = (phase_q != 2'd1);
        last_phase = (phase_q == 2'd1);
      end
      RATE_3_4: begin
        keep_x = (phase_q != 2'd1);
        keep_y = (phase_q != 2'd2);
        last_phase = (phase_q == 2'd2);
      end
      default: ;
    endcase
    need = {1'b0, keep_x} + {1'b0, keep_y};
  end

  assign in_ready  = (cnt_q <= 2'd1);
  assign take      = in_valid && in_ready;
  assign step_fire = step_go && (cnt_q >= need);
  assign used      = step_fire ? need : 2'd0;

  always_comb begin
    sym.x  = keep_x ? dbuf_q[0] : 1'b0;
    sym.ex = keep_x ? ebuf_q[0] : 1'b1;
    sym.y  = keep_y ? (keep_x ? dbuf_q[1] : dbuf_q[0]) : 1'b0;
    sym.ey = keep_y ? (keep_x ? ebuf_q[1] : ebuf_q[0]) : 1'b1;
  end

  always_comb begin
    dbuf_d = dbuf_q >> used;
    ebuf_d = ebuf_q >> used;
    cnt_d  = cnt_q - used;
    if (take) begin
      dbuf_d[cnt_d]        = in_bits[0];
      ebuf_d[cnt_d]        = in_erase[0];
      dbuf_d[cnt_d + 2'd1] = in_bits[1];
      ebuf_d[cnt_d + 2'd1] = in_erase[1];
      cnt_d = cnt_d + 2'd2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbuf_q  <= '0;
      ebuf_q  <= '0;
      cnt_q   <= '0;
      phase_q <= '0;
    end else begin
      dbuf_q <= dbuf_d;
      ebuf_q <= ebuf_d;
      cnt_q  <= cnt_d;
      if (step_fire) phase_q <= last_phase ? 2'd0 : phase_q + 2'd1;
    end
  end

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate != RATE_3_4) |-> (phase_q <= 2'd1));

  // R7
  take_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cnt_q != 2'd0));
endmodule

// File: rtl/k7vit_acs.sv
module k7vit_acs
  import k7vit_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int PM_W  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  sym_t sym,
  output logic best_bit
);
  localparam logic [PM_W-1:0] PM_MAX = '1;

  logic [NSTATE-1:0][PM_W-1:0]  pm_w;
  logic [NSTATE-1:0][DEPTH-1:0] surv_w;
  logic [PM_W-1:0]   minv;
  logic [SIDX_W-1:0] best_idx;

  // best-metric search, lowest index wins ties
  always_comb begin
    minv = pm_w[0];
    best_idx = '0;
    for (int i = 1; i < NSTATE; i++) begin
      if (pm_w[i] < minv) begin
        minv = pm_w[i];
        best_idx = SIDX_W'(i);
      end
    end
  end

  assign best_bit = surv_w[best_idx][DEPTH-1];

  for (genvar s = 0; s < NSTATE; s++) begin : g_state
    localparam logic [SIDX_W-1:0] S  = SIDX_W'(s);
    localparam logic [SIDX_W-1:0] P0 = {S[SIDX_W-2:0], 1'b0};
    localparam logic [SIDX_W-1:0] P1 = {S[SIDX_W-2:0], 1'b1};

    logic [PM_W-1:0]  pm_q;
    logic [DEPTH-1:0] surv_q;
    logic [1:0]       bm0, bm1;
    logic [PM_W:0]    c0, c1, pick, norm;
    logic             from1;
    logic [PM_W-1:0]  pm_d;

    assign bm0   = hamming(sym, code_pair({S, 1'b0}));
    assign bm1   = hamming(sym, code_pair({S, 1'b1}));
    assign c0    = {1'b0, pm_w[P0]} + {{(PM_W-1){1'b0}}, bm0};
    assign c1    = {1'b0, pm_w[P1]} + {{(PM_W-1){1'b0}}, bm1};
    assign from1 = (c1 < c0);
    assign pick  = from1 ? c1 : c0;
    assign norm  = pick - {1'b0, minv};
    assign pm_d  = norm[PM_W] ? PM_MAX : norm[PM_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pm_q   <= (s == 0) ? '0 : PM_MAX;
        surv_q <= '0;
      end else if (step) begin
        pm_q   <= pm_d;
        surv_q <= {(from1 ? surv_w[P1][DEPTH-2:0] : surv_w[P0][DEPTH-2:0]), S[SIDX_W-1]};
      end
    end

    assign pm_w[s]   = pm_q;
    assign surv_w[s] = surv_q;
  end

  // R4
  pm_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    minv <= PM_W'(2));
endmodule

// File: rtl/k7vit_errcnt.sv
module k7vit_errcnt
  import k7vit_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  sym_t             sym,
  input  logic             emit,
  input  logic             dec_bit,
  input  logic [CNT_W-1:0] win_len,
  output logic [CNT_W-1:0] err_count,
  output logic             err_done
);
  sym_t [DEPTH-1:0]  dly_q;
  logic [SIDX_W-1:0] enc_q;
  logic [CNT_W-1:0]  acc_q, wcnt_q;
  logic [1:0]        code, mism;
  logic [CNT_W:0]    sum;
  logic [CNT_W-1:0]  sum_sat;
  logic              win_end;
  sym_t              old;

  assign old     = dly_q[DEPTH-1];
  assign code    = code_pair({dec_bit, enc_q});
  assign mism    = hamming(old, code);
  assign sum     = {1'b0, acc_q} + {{(CNT_W-1){1'b0}}, mism};
  assign sum_sat = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  assign win_end = ({1'b0, wcnt_q} + 1'b1) == {1'b0, win_len};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_q     <= '0;
      enc_q     <= '0;
      acc_q     <= '0;
      wcnt_q    <= '0;
      err_count <= '0;
      err_done  <= 1'b0;
    end else begin
      err_done <= 1'b0;
      if (step) dly_q <= {dly_q[DEPTH-2:0], sym};
      if (emit) begin
        enc_q <= {dec_bit, enc_q[SIDX_W-1:1]};
        if (win_end) begin
          err_count <= sum_sat;
          err_done  <= 1'b1;
          acc_q     <= '0;
          wcnt_q    <= '0;
        end else begin
          acc_q  <= sum_sat;
          wcnt_q <= wcnt_q + 1'b1;
        end
      end
    end
  end

  // R8
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_done |-> ({1'b0, err_count} <= {win_len, 1'b0}));

  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_done |-> $past(emit));
endmodule

// File: rtl/k7_viterbi_dec.sv
module k7_viterbi_dec
  import k7vit_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int PM_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate_sel,
  input  logic [CNT_W-1:0] win_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_bits,
  input  logic [1:0]       in_erase,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit,
  output logic [CNT_W-1:0] err_count,
  output logic             err_done
);
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(DEPTH);

  logic             step_go, step, emit, best_bit;
  sym_t             sym;
  logic [FILL_W-1:0] fill_q;

  assign step_go = !out_valid || out_ready;
  assign emit    = step && (fill_q == FILL_FULL);

  k7vit_depunct u_depunct (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bits   (in_bits),
    .in_erase  (in_erase),
    .step_go   (step_go),
    .step_fire (step),
    .sym       (sym)
  );

  k7vit_acs #(.DEPTH(DEPTH), .PM_W(PM_W)) u_acs (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .sym      (sym),
    .best_bit (best_bit)
  );

  k7vit_errcnt #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_errcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .sym       (sym),
    .emit      (emit),
    .dec_bit   (best_bit),
    .win_len   (win_len),
    .err_count (err_count),
    .err_done  (err_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q    <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      if (step && fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
      if (emit) begin
        out_valid <= 1'b1;
        out_bit   <= best_bit;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R10
  early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (fill_q == FILL_FULL));
endmodule

// File: tb/k7_viterbi_dec_bench.sv
module k7_viterbi_dec_bench;
  localparam int CLK_NS = 10;
  localparam int NDATA  = 72;
  localparam int NSTEP  = 120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate_sel = 2'd0;
  logic [15:0] win_len = 16'd72;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_bits = 2'b00;
  logic [1:0]  in_erase = 2'b00;
  logic        out_valid;
  logic        out_ready;
  logic        out_bit;
  logic [15:0] err_count;
  logic        err_done;

  always #(CLK_NS/2) clk = ~clk;

  k7_viterbi_dec u_k7_viterbi_dec (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .win_len(win_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_bits(in_bits), .in_erase(in_erase),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .err_count(err_count), .err_done(err_done)
  );

  int n_tot = 0, n_fail = 0;
  bit finished = 0;

  logic data_b [0:NSTEP-1];
  logic cb [0:511];
  logic ce [0:511];
  int   cs [0:511];
  int   nc;
  int   err_step [0:NSTEP-1];

  logic got [0:255];
  int   ngot;
  logic [15:0] errs [0:15];
  int   nerr;
  int   rdy_mode = 0;
  int   cyc = 0;
  bit   hold_pend = 0;
  logic hold_bit = 0;
  int   hold_viol = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // port observer: ready pattern, output capture, hold rule, error reports
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (((cyc >> 1) ^ (cyc >> 3)) & 1) != 0;
      default: out_ready = 1'b0;
    endcase
    if (rst_n) begin
      if (hold_pend && !(out_valid && out_bit == hold_bit)) hold_viol++;
      hold_pend = out_valid && !out_ready;
      hold_bit  = out_bit;
      if (out_valid && out_ready && ngot < 256) begin
        got[ngot] = out_bit;
        ngot++;
      end
      if (err_done && nerr < 16) begin
        errs[nerr] = err_count;
        nerr++;
      end
    end
  end

  task automatic do_reset(input logic [1:0] r, input logic [15:0] w);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    rate_sel = r;
    win_len = w;
    repeat (3) @(negedge clk);
    ngot = 0;
    nerr = 0;
    hold_pend = 0;
    hold_viol = 0;
    rst_n = 1'b1;
  endtask

  // reference encoder plus puncturing, channel flips and erasures
  task automatic build(input logic [1:0] r, input logic [15:0] seed,
                       input int flip_every, input int erase_every);
    logic [5:0]  st;
    logic [15:0] lf;
    logic [6:0]  w;
    logic        x, y, kx, ky;
    int          ph;
    st = '0;
    lf = seed;
    nc = 0;
    for (int i = 0; i < NSTEP; i++) begin
      err_step[i] = 0;
      data_b[i] = (i < NDATA) ? lf[0] : 1'b0;
      lf = {1'b0, lf[15:1]} ^ (lf[0] ? 16'hB400 : 16'h0000);
      w = {data_b[i], st};
      x = ^(w & 7'o171);
      y = ^(w & 7'o133);
      st = w[6:1];
      kx = 1'b1;
      ky = 1'b1;
      if (r == 2'd1) begin
        ph = i % 2;
        kx = (ph != 1);
      end else if (r == 2'd2) begin
        ph = i % 3;
        kx = (ph != 1);
        ky = (ph != 2);
      end
      if (kx) begin cb[nc] = x; ce[nc] = 1'b0; cs[nc] = i; nc++; end
      if (ky) begin cb[nc] = y; ce[nc] = 1'b0; cs[nc] = i; nc++; end
    end
    for (int j = 0; j < nc; j++) begin
      if (erase_every > 0 && (j % erase_every) == erase_every - 1) begin
        ce[j] = 1'b1;
        cb[j] = ~cb[j];
      end else if (flip_every > 0 && (j % flip_every) == flip_every - 1) begin
        cb[j] = ~cb[j];
        if (cs[j] < NDATA) err_step[cs[j]]++;
      end
    end
  endtask

  task automatic send_beats(input int first, input int last);
    int i;
    i = first;
    while (i < last) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bits  = {cb[2*i+1], cb[2*i]};
      in_erase = {ce[2*i+1], ce[2*i]};
      if (in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out(input int n);
    int t;
    t = 0;
    while (ngot < n && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(2'd0, 16'd72);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(err_done == 1'b0, "R9", "err_done after reset", err_done, 0);
    chk(err_count == 16'd0, "R9", "err_count after reset", err_count, 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
  endtask

  // R10 latency and R7 input back-pressure with a blocked consumer
  task automatic t_latency();
    rdy_mode = 2;
    do_reset(2'd0, 16'd1000);
    build(2'd0, 16'h0001, 0, 0);
    for (int j = 0; j < 2*NSTEP; j++) begin cb[j] = 1'b0; ce[j] = 1'b0; end
    send_beats(0, 48);
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R10", "no output after 48 steps", out_valid, 0);
    send_beats(48, 49);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R10", "output after 49th step", out_valid, 1);
    chk(out_bit == 1'b0, "R10", "first decoded bit", out_bit, 0);
    send_beats(49, 50);
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b0, "R7", "in_ready low with two bits held", in_ready, 0);
    chk(out_valid == 1'b1 && out_bit == 1'b0, "R6", "output held while blocked", out_valid, 1);
    rdy_mode = 0;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R7", "in_ready back after release", in_ready, 1);
    chk(ngot == 2, "R6", "bits delivered after release", ngot, 2);
  endtask

  task automatic t_stream(input string req, input logic [1:0] r, input logic [15:0] seed,
                          input int flip_every, input int erase_every, input int win, input int rmode);
    int bad, nwin, e;
    rdy_mode = rmode;
    do_reset(r, 16'(win));
    build(r, seed, flip_every, erase_every);
    send_beats(0, nc / 2);
    wait_out(NDATA);
    chk(ngot == NDATA, req, "decoded bit count", ngot, NDATA);
    bad = 0;
    for (int i = 0; i < NDATA; i++) if (i < ngot && got[i] !== data_b[i]) bad++;
    chk(bad == 0, req, "decoded bit mismatches", bad, 0);
    nwin = NDATA / win;
    chk(nerr == nwin, "R8", "error windows reported", nerr, nwin);
    for (int k = 0; k < nwin; k++) begin
      e = 0;
      for (int i = k*win; i < (k+1)*win; i++) e += err_step[i];
      chk(k < nerr && int'(errs[k]) == e, "R8", $sformatf("window %0d error count", k),
          (k < nerr) ? int'(errs[k]) : -1, e);
    end
    chk(hold_viol == 0, "R6", "output hold violations", hold_viol, 0);
    rdy_mode = 0;
  endtask

  initial begin
    out_ready = 1'b1;
    t_reset();
    t_latency();
    t_stream("R1", 2'd0, 16'hACE1, 0, 0, 72, 0);
    t_stream("R2", 2'd1, 16'h1D2B, 0, 0, 72, 0);
    t_stream("R3", 2'd2, 16'h7A55, 0, 0, 72, 1);
    t_stream("R1", 2'd3, 16'h3C3C, 0, 0, 36, 0);
    t_stream("R4", 2'd0, 16'hBEEF, 17, 0, 24, 1);
    t_stream("R4", 2'd2, 16'h0F0F, 31, 0, 36, 0);
    t_stream("R5", 2'd2, 16'h5AA5, 0, 13, 72, 0);
    t_stream("R5", 2'd0, 16'h2468, 23, 9, 24, 1);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tot++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  end
endmodule